// File: doc/BRIEF.md
# Circular Audio Read DMA Engine

This block is one playback DMA channel. It reads a ring buffer in memory with incrementing read bursts and keeps a small word FIFO filled for an audio serial transmitter. Software sets up the channel through a small register port. It writes the ring base address, the ring length and the period length, both as a count of 32-bit words minus one, and then a control word. The control word sets enable, burst mode, the FIFO watermark, the target serial interface and the number of words in one sample frame.

Once enabled, the engine fetches on its own. It starts again at the base address after the last word of the ring, and it flags a period event each time a full period of words has arrived. A live current-address register gives the playback position: current minus base is the byte offset into the ring. Three event sources share one interrupt line through status, enable and write-one-to-clear registers: period elapsed, underrun and bus error.

Top module: `audio_ring_dma`

## Requirements
- R1: After reset the interrupt line, `mem_req` and `tx_valid` are low, and the control, current-address, status and enable registers all read 0.
- R2: Register word addresses are: 0 control, 1 base, 2 ring length, 3 period length, 4 current address (read-only), 5 status (read-only), 6 interrupt enable, 7 clear (write-only, reads 0). Control bits are: [0] enable, [1] burst mode, [4:2] words per frame minus one, [7:5] interface select, [11:8] watermark. Bits [4:2] drive `tx_wps` and bits [7:5] drive `tx_port`.
- R3: A fetch starts only when the channel is enabled, no request or beat is outstanding, and the FIFO fill is at or below the watermark. It is 4 beats when burst mode is set and at least 4 words remain before the ring end. Otherwise it is 1 beat, at `mem_addr` = the current address.
- R4: The current address equals base + 4 × (words accepted since the last flush, modulo ring length + 1). After the word at offset (ring length) it returns to the base address.
- R5: Accepted words appear on `tx_data` in fetch order. `tx_valid` is high while the FIFO holds a word, and `tx_pop` removes the head word.
- R6: Status bit 0 (period) is set each time the count of accepted words reaches a multiple of period length + 1.
- R7: Status bit 1 (underrun) is set when `tx_pop` is high, the FIFO is empty and the channel is enabled. When the channel is disabled the same stimulus leaves it clear.
- R8: A read beat with `mem_rerr` high sets status bit 2 (bus error) and clears the enable bit. That beat and the rest of its burst are discarded, and the current address stays where it was.
- R9: Writing 1 to a bit of the clear register clears that status bit. A bit that is set and cleared in the same cycle stays set.
- R10: `irq` is high when any status bit is set and its enable bit (same position) is set.
- R11: With enable clear, no new request is made, arriving beats are dropped, and the FIFO and current address are kept, so fetching resumes losslessly. Writing 0 to the whole control register also empties the FIFO and resets the ring position and period count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Read request, held until granted |
| mem_addr | output | 32 | Byte address of the first beat |
| mem_len | output | 3 | Beats in the request (1 or 4) |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |
| mem_rerr | input | 1 | Read beat carries a bus error |
| tx_pop | input | 1 | Transmitter takes the head word |
| tx_valid | output | 1 | FIFO holds a word |
| tx_data | output | 32 | Head word of the FIFO |
| tx_port | output | 3 | Selected serial interface |
| tx_wps | output | 3 | Words per sample frame minus one |
| irq | output | 1 | Combined interrupt |

## Verification
The fetch path is tried with four ring and period shapes: a ring that is a multiple of the burst, single-beat mode, a ring length that forces single beats before the wrap, and a large ring with a low watermark. From idle, each shape ends on a known count of accepted words. This separates errors in the watermark test, the burst-length choice and the wrap point through the current address, the period bit and the popped word sequence. Directed cases then cover pause and resume, a bus error in mid-burst, underrun with enable set and clear, interrupt gating and a clear that lands in the same cycle as a new event.

// File: rtl/audio_ring_dma.sv
module audio_ring_dma #(
  parameter int LEN_W = 16,
  parameter int DEPTH = 16,
  parameter int BURST = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  output logic [2:0]  mem_len,
  input  logic        mem_gnt,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  input  logic        mem_rerr,
  input  logic        tx_pop,
  output logic        tx_valid,
  output logic [31:0] tx_data,
  output logic [2:0]  tx_port,
  output logic [2:0]  tx_wps,
  output logic        irq
);
  localparam int FW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);

  logic [11:0]      ctrl_q;
  logic [31:0]      base_q;
  logic [LEN_W-1:0] blen_q, plen_q, off_q, pcnt_q;
  logic [2:0]       stat_q, ien_q;
  logic             req_q;
  logic [2:0]       len_q, left_q;
  logic [31:0]      fifo_q [DEPTH];
  logic [PW-1:0]    wp_q, rp_q;
  logic [FW-1:0]    fill_q;

  wire en      = ctrl_q[0];
  wire wr_ctrl = reg_we && reg_addr == 3'd0;
  wire wr_clr  = reg_we && reg_addr == 3'd7;
  wire flush   = wr_ctrl && reg_wdata[11:0] == 12'd0;

  wire [LEN_W:0] to_end = {1'b0, blen_q} - {1'b0, off_q} + 1'b1;
  wire launch = en && !req_q && left_q == 3'd0 &&
                32'(fill_q) <= 32'(ctrl_q[11:8]) && 32'(fill_q) <= DEPTH - BURST;
  wire beat   = mem_rvalid && left_q != 3'd0;
  wire take   = beat && en && !mem_rerr && !flush;
  wire berr   = beat && mem_rerr;
  wire pop    = tx_pop && fill_q != '0;
  wire xrun   = tx_pop && fill_q == '0 && en;
  wire per_hit = take && pcnt_q == plen_q;

  wire [31:0] curr = base_q + 32'({off_q, 2'b00});

  assign mem_req  = req_q;
  assign mem_addr = curr;
  assign mem_len  = len_q;
  assign tx_valid = fill_q != '0;
  assign tx_data  = fifo_q[rp_q];
  assign tx_port  = ctrl_q[7:5];
  assign tx_wps   = ctrl_q[4:2];
  assign irq      = |(stat_q & ien_q);

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = 32'(ctrl_q);
      3'd1:    reg_rdata = base_q;
      3'd2:    reg_rdata = 32'(blen_q);
      3'd3:    reg_rdata = 32'(plen_q);
      3'd4:    reg_rdata = curr;
      3'd5:    reg_rdata = 32'(stat_q);
      3'd6:    reg_rdata = 32'(ien_q);
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
      blen_q <= '0;
      plen_q <= '0;
      ien_q  <= '0;
      stat_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata[11:0];
      if (berr)    ctrl_q[0] <= 1'b0;
      if (reg_we && reg_addr == 3'd1) base_q <= reg_wdata;
      if (reg_we && reg_addr == 3'd2) blen_q <= reg_wdata[LEN_W-1:0];
      if (reg_we && reg_addr == 3'd3) plen_q <= reg_wdata[LEN_W-1:0];
      if (reg_we && reg_addr == 3'd6) ien_q  <= reg_wdata[2:0];
      stat_q <= (stat_q & ~(wr_clr ? reg_wdata[2:0] : 3'b000)) | {berr, xrun, per_hit};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      off_q  <= '0;
      pcnt_q <= '0;
    end else if (take) begin
      off_q  <= (off_q == blen_q) ? '0 : off_q + 1'b1;
      pcnt_q <= per_hit ? '0 : pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      len_q  <= 3'd1;
      left_q <= '0;
    end else begin
      if (beat) left_q <= left_q - 1'b1;
      if (req_q && mem_gnt) begin
        req_q  <= 1'b0;
        left_q <= len_q;
      end else if (!en || flush) begin
        req_q <= 1'b0;
      end else if (launch) begin
        req_q <= 1'b1;
        len_q <= (ctrl_q[1] && to_end >= (LEN_W+1)'(BURST)) ? 3'(BURST) : 3'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      if (take) wp_q <= (32'(wp_q) == DEPTH - 1) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (32'(rp_q) == DEPTH - 1) ? '0 : rp_q + 1'b1;
      fill_q <= fill_q + FW'(take) - FW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (take) fifo_q[wp_q] <= mem_rdata;
  end
endmodule

// File: rtl/audio_ring_dma_chk.sv
module audio_ring_dma_chk #(
  parameter int BURST = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [2:0] stat,
  input logic [2:0] ien,
  input logic [2:0] left,
  input logic       mem_req,
  input logic [2:0] mem_len,
  input logic       mem_rvalid,
  input logic       mem_rerr,
  input logic       tx_pop,
  input logic       tx_valid,
  input logic       clr_xrun,
  input logic       irq
);
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len == 3'd1 || mem_len == 3'(BURST))); // R3
  AST_BEAT_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> left != 3'd0); // R3
  AST_BERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid && mem_rerr && left != 3'd0) |=> (!en && stat[2])); // R8
  AST_CLR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && !tx_valid && en && clr_xrun) |=> stat[1]); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 3'd0) |-> !irq); // R10
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mem_req); // R11
endmodule

bind audio_ring_dma audio_ring_dma_chk #(.BURST(BURST)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_q[0]), .stat(stat_q), .ien(ien_q),
  .left(left_q), .mem_req(mem_req), .mem_len(mem_len), .mem_rvalid(mem_rvalid),
  .mem_rerr(mem_rerr), .tx_pop(tx_pop), .tx_valid(tx_valid),
  .clr_xrun(reg_we && reg_addr == 3'd7 && reg_wdata[1]), .irq(irq)
);

// File: tb/test_audio_ring_dma.sv
module test_audio_ring_dma;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0001_0000;
  // columns: ring len-1, period len-1, burst, watermark, words accepted, end offset, period set
  localparam int NV = 4;
  localparam int VEC [NV][7] = '{
    '{7,    3,   1, 8, 12, 4, 1},
    '{7,    15,  0, 8, 9,  1, 0},
    '{5,    1,   1, 8, 10, 4, 1},
    '{1023, 511, 1, 4, 8,  8, 0}
  };

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_gnt = 0, mem_rvalid = 0, mem_rerr = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic [2:0] mem_len, tx_port, tx_wps;
  logic tx_pop = 0, tx_valid, irq;
  logic [31:0] tx_data;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  int checks = 0, errors = 0;
  bit done = 0;

  audio_ring_dma i_audio_ring_dma (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin : memory_model
    logic [31:0] ma;
    int mb;
    mb = 0; ma = 0;
    forever begin
      @(negedge clk);
      mem_gnt = 0; mem_rvalid = 0; mem_rerr = 0;
      if (mb > 0) begin
        mem_rvalid = 1; mem_rdata = ~ma; mem_rerr = (ma == err_addr);
        ma = ma + 4; mb = mb - 1;
      end else if (mem_req) begin
        mem_gnt = 1; ma = mem_addr; mb = int'(mem_len);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pops(input int n, input int start, input int ringw, output int bad);
    bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (!tx_valid || tx_data != ~(BASE + 32'(4 * ((start + k) % ringw)))) bad++;
      tx_pop = 1;
    end
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic setup(input int ringm1, input int perm1);
    wr(0, 0); wr(1, BASE); wr(2, 32'(ringm1)); wr(3, 32'(perm1)); wr(7, 7);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int bad;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!irq && !mem_req && !tx_valid, "R1 outputs", {irq, mem_req, tx_valid}, 0);
    rd(0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(4, d); chk(d == 0, "R1 curr", d, 0);
    rd(5, d); chk(d == 0, "R1 stat", d, 0);

    // R2 register fields
    wr(0, 32'h0000_0074); // port 3, wps code 5, enable clear
    chk(tx_wps == 3'd5 && tx_port == 3'd3, "R2 fields", {tx_port, tx_wps}, {3'd3, 3'd5});
    rd(0, d); chk(d == 32'h74, "R2 ctrl readback", d, 32'h74);
    wr(2, 32'd4095); rd(2, d); chk(d == 4095, "R2 ring length", d, 4095);
    rd(7, d); chk(d == 0, "R2 clear reads zero", d, 0);

    // R3 R4 R5 R6: vector table
    for (int v = 0; v < NV; v++) begin
      setup(VEC[v][0], VEC[v][1]);
      wr(0, 32'(1 | (VEC[v][2] << 1) | (VEC[v][3] << 8)));
      repeat (60) @(negedge clk);
      rd(4, d);
      chk(d == BASE + 32'(4 * VEC[v][5]), $sformatf("R3 R4 vec%0d curr", v), d, BASE + 32'(4 * VEC[v][5]));
      rd(5, d);
      chk(d[0] == VEC[v][6][0], $sformatf("R6 vec%0d period", v), d[0], VEC[v][6]);
      pops(VEC[v][4], 0, VEC[v][0] + 1, bad);
      chk(bad == 0, $sformatf("R5 vec%0d data order", v), bad, 0);
      wr(0, 0);
      repeat (10) @(negedge clk);
      chk(!tx_valid, $sformatf("R11 vec%0d flush", v), tx_valid, 0);
    end

    // R11 pause and resume
    setup(7, 3);
    wr(0, 32'h0000_0803);
    repeat (60) @(negedge clk);
    wr(0, 32'h0000_0802);
    pops(8, 0, 8, bad);
    repeat (20) @(negedge clk);
    rd(4, d); chk(d == BASE + 16, "R11 paused curr", d, BASE + 16);
    chk(tx_valid && !mem_req, "R11 paused fifo kept", {tx_valid, mem_req}, 2'b10);
    wr(0, 32'h0000_0803);
    repeat (20) @(negedge clk);
    pops(8, 8, 8, bad);
    chk(bad == 0, "R11 resume order", bad, 0);
    wr(0, 0);

    // R8 bus error mid-burst
    setup(7, 15);
    err_addr = BASE + 8;
    wr(0, 32'h0000_0803);
    repeat (30) @(negedge clk);
    rd(0, d); chk(d[0] == 0, "R8 enable cleared", d[0], 0);
    rd(5, d); chk(d[2] == 1, "R8 status", d[2], 1);
    rd(4, d); chk(d == BASE + 8, "R8 curr", d, BASE + 8);
    pops(2, 0, 8, bad);
    chk(bad == 0 && !tx_valid, "R8 words dropped", {bad[7:0], tx_valid}, 0);
    err_addr = 32'hFFFF_FFFF;

    // R7 R10 R9 underrun and interrupt gating
    setup(7, 15);
    wr(6, 0);
    wr(0, 32'h0000_0803);
    tx_pop = 1; @(negedge clk); tx_pop = 0;
    rd(5, d); chk(d[1] == 1, "R7 underrun", d[1], 1);
    chk(!irq, "R10 masked", irq, 0);
    wr(6, 2); #1; chk(irq, "R10 enabled", irq, 1);
    wr(7, 2); rd(5, d); chk(d[1] == 0, "R9 w1c", d[1], 0);
    #1; chk(!irq, "R10 after clear", irq, 0);
    wr(0, 0);
    @(negedge clk); reg_we = 1; reg_addr = 0; reg_wdata = 32'h0000_0003;
    @(negedge clk); reg_addr = 7; reg_wdata = 2; tx_pop = 1;
    @(negedge clk); reg_we = 0; tx_pop = 0;
    rd(5, d); chk(d[1] == 1, "R9 set wins over clear", d[1], 1);
    wr(0, 0); wr(7, 7);
    tx_pop = 1; @(negedge clk); tx_pop = 0;
    rd(5, d); chk(d[1] == 0, "R7 disabled no underrun", d[1], 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule